// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for one audio serial port. The system clock `clk` is the oversampling master clock; a divider chain derives the bit clock from it, and a bit counter derives the frame clock from the bit clock. Two coded fields in a clock configuration word choose the ratio between the master clock and the sample rate and the number of bit clocks in one frame. The half period of the bit clock is ratio / (2 x bits-per-frame) master-clock cycles.

Two master/slave bits in the same word, one for the receive direction and one for the transmit direction, decide where each direction's data shifter takes its clocks from. A direction in master mode uses the internal clocks. A direction in slave mode uses the external clock pins. A polarity word holds four separate inversion bits: two act on the driven pads in master mode and two act on the external pins in slave mode. A shared run word gates the generator, and the parameter `PORT_SEL` chooses which bit of that word belongs to this port.

The sequencing is a three-state machine. ST_IDLE holds both clocks low. ST_IDLE goes to ST_RUN when the run bit is set. ST_RUN goes to ST_DRAIN when the run bit clears in the middle of a frame, and goes straight to ST_IDLE when the run bit is clear on the last falling bit-clock edge of a frame. ST_DRAIN goes back to ST_RUN when the run bit returns. ST_DRAIN goes to ST_IDLE at the end of the frame when the run bit is still clear, and goes to ST_RUN at the end of the frame when the run bit is set again.

Top module: `aud_sclk_gen`

## Requirements
- R1: After reset, with the run bit clear, the internal bit clock and frame clock are low. Each pad output then equals its master inversion bit, and `pad_oe_o` is 0 when both master bits are 0.
- R2: `ckcfg_i[14:12]` sets the master-clock ratio M: codes 0, 1, 2, 3, 4 give 512, 256, 128, 64, 32. The bit clock period is M/B cycles of `clk`, where B is the frame length from R3.
- R3: `ckcfg_i[10:8]` sets the frame length B in bit clocks: codes 0, 1, 2, 3, 4 give 32, 64, 128, 256, 512, and code 7 gives 16. The frame clock is low for B/2 bit clocks and then high for B/2 bit clocks.
- R4: Ratio codes 5 to 7 behave as ratio code 0. Frame codes 5 and 6 behave as frame code 0.
- R5: When M < 2B, the bit clock period is 2 cycles of `clk`.
- R6: Every frame clock edge falls on the same `clk` edge as a falling bit clock edge. Each frame starts with the frame clock low.
- R7: Port A (`PORT_SEL`=0) runs from `run_bus_i[0]`; port B (`PORT_SEL`=1) runs from `run_bus_i[4]`. The other bit has no effect.
- R8: When the run bit clears, both clocks keep toggling until the current frame ends. They then stay at their inactive level (low before inversion).
- R9: The ratio and frame codes are captured when the run starts and again at each frame boundary. A change in the middle of a frame takes effect with the next frame.
- R10: `polcfg_i[12]` inverts the frame clock pad and `polcfg_i[8]` inverts the bit clock pad.
- R11: `ckcfg_i[0]` makes the transmit direction a clock master and `ckcfg_i[4]` makes the receive direction a clock master. A master direction sees the internal clocks without inversion. A slave direction sees `ext_bck_i` XOR `polcfg_i[0]` and `ext_lrc_i` XOR `polcfg_i[4]`.
- R12: `pad_oe_o` is 1 exactly when either master bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ckcfg_i | input | 16 | Clock configuration word: ratio code, frame code, master bits |
| polcfg_i | input | 16 | Polarity word with four inversion bits |
| run_bus_i | input | 8 | Shared run word for both ports |
| ext_bck_i | input | 1 | External bit clock used in slave mode |
| ext_lrc_i | input | 1 | External frame clock used in slave mode |
| bck_pad_o | output | 1 | Bit clock pad after master inversion |
| lrc_pad_o | output | 1 | Frame clock pad after master inversion |
| pad_oe_o | output | 1 | Drive enable for both clock pads |
| tx_bck_o | output | 1 | Bit clock for the transmit shifter |
| tx_lrc_o | output | 1 | Frame clock for the transmit shifter |
| rx_bck_o | output | 1 | Bit clock for the receive shifter |
| rx_lrc_o | output | 1 | Frame clock for the receive shifter |

## Verification
The generated clocks come from registers. After the run bit is sampled, the bit clock first rises 2^(h+1)/2 cycles later, where h is the half-period exponent. The frame clock moves only on the same edge as a bit clock fall.

The routing and inversion paths are purely combinational. They are checked a fraction of a nanosecond after the inputs change, inside the same clock period.

The bench never predicts an absolute edge time for the divider outputs. It samples every falling `clk` edge and compares intervals: cycles between bit-clock rises, and bit-clock falls during the high half of the frame clock. This keeps each check independent of the start-up latency.

The stop and reconfiguration checks are anchored to a frame clock rise, which is the middle of a frame. The effect is then checked at the frame clock fall that ends that frame.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;

    // width of the half-period exponent and of the frame-length exponent
    localparam int HL_W = 3;
    localparam int FL_W = 4;

    // exponent of the largest master-clock ratio (512) and of the default frame (32)
    localparam int MCLK_LOG_TOP    = 9;
    localparam int FRAME_LOG_BASE  = 5;
    localparam int FRAME_LOG_SHORT = 4;
    localparam int RATIO_CODE_MAX  = 4;
    localparam int FRAME_CODE_MAX  = 4;
    localparam int FRAME_CODE_16   = 7;

    // largest half-period exponent the decoder can produce
    localparam int MAX_HALF_LOG = MCLK_LOG_TOP - FRAME_LOG_SHORT - 1;
    localparam int MAX_FRAME_LOG = FRAME_LOG_BASE + FRAME_CODE_MAX;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sclk_state_e;

endpackage

// File: rtl/aud_sclk_decode.sv
module aud_sclk_decode
    import aud_sclk_pkg::*;
(
    input  logic [2:0]      ratio_code_i,
    input  logic [2:0]      frame_code_i,
    output logic [HL_W-1:0] half_log_o,
    output logic [FL_W-1:0] frame_log_o
);

    int mlog;
    int flog;
    int hl;

    always_comb begin
        // ratio: code n selects 512 >> n, unused codes behave as code 0
        if (int'(ratio_code_i) <= RATIO_CODE_MAX) begin
            mlog = MCLK_LOG_TOP - int'(ratio_code_i);
        end else begin
            mlog = MCLK_LOG_TOP;
        end

        // frame length: code n selects 32 << n, code 7 gives 16, others fall back
        if (int'(frame_code_i) <= FRAME_CODE_MAX) begin
            flog = FRAME_LOG_BASE + int'(frame_code_i);
        end else if (int'(frame_code_i) == FRAME_CODE_16) begin
            flog = FRAME_LOG_SHORT;
        end else begin
            flog = FRAME_LOG_BASE;
        end

        // half period = M / (2B); clamp at one master clock when M < 2B
        if (mlog > flog) begin
            hl = mlog - flog - 1;
        end else begin
            hl = 0;
        end

        half_log_o  = HL_W'(hl);
        frame_log_o = FL_W'(flog);
    end

    // R2: exponent never exceeds the counter's reach
    always_comb begin
        p_half_range_r2: assert (int'(half_log_o) <= MAX_HALF_LOG);
    end

endmodule

// File: rtl/aud_sclk_divider.sv
module aud_sclk_divider
    import aud_sclk_pkg::*;
#(
    parameter int HCNT_W = MAX_HALF_LOG,
    parameter int BCNT_W = MAX_FRAME_LOG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [HL_W-1:0] dec_hl_i,
    input  logic [FL_W-1:0] dec_flog_i,
    output logic            bck_o,
    output logic            lrc_o
);

    sclk_state_e st_q, st_nx;

    logic [HCNT_W-1:0] hcnt_q;
    logic [BCNT_W-1:0] bitcnt_q;
    logic              bclk_q, lrck_q;
    logic [HL_W-1:0]   cur_hl_q;
    logic [FL_W-1:0]   cur_flog_q;

    logic [HCNT_W-1:0] half_last;
    logic [BCNT_W-1:0] frame_last;
    logic [BCNT_W-1:0] mid_last;
    logic              tick, fall, frame_end, mid_pt;

    // terminal counts from the captured exponents
    always_comb begin
        half_last  = HCNT_W'((32'd1 << cur_hl_q) - 32'd1);
        frame_last = BCNT_W'((32'd1 << cur_flog_q) - 32'd1);
        mid_last   = BCNT_W'((32'd1 << (cur_flog_q - FL_W'(1))) - 32'd1);
        tick       = (st_q != ST_IDLE) && (hcnt_q == half_last);
        fall       = tick && bclk_q;
        frame_end  = fall && (bitcnt_q == frame_last);
        mid_pt     = fall && (bitcnt_q == mid_last);
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (run_i) st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (frame_end && !run_i) st_nx = ST_IDLE;
                else if (!run_i)         st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (frame_end)  st_nx = run_i ? ST_RUN : ST_IDLE;
                else if (run_i) st_nx = ST_RUN;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // counters and clock outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q     <= '0;
            bitcnt_q   <= '0;
            bclk_q     <= 1'b0;
            lrck_q     <= 1'b0;
            cur_hl_q   <= '0;
            cur_flog_q <= FL_W'(FRAME_LOG_BASE);
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    hcnt_q   <= '0;
                    bitcnt_q <= '0;
                    bclk_q   <= 1'b0;
                    lrck_q   <= 1'b0;
                    if (run_i) begin
                        cur_hl_q   <= dec_hl_i;
                        cur_flog_q <= dec_flog_i;
                    end
                end
                ST_RUN, ST_DRAIN: begin
                    if (tick) begin
                        hcnt_q <= '0;
                        bclk_q <= ~bclk_q;
                        if (fall) begin
                            if (frame_end) begin
                                bitcnt_q <= '0;
                                lrck_q   <= 1'b0;
                                if (run_i) begin
                                    cur_hl_q   <= dec_hl_i;
                                    cur_flog_q <= dec_flog_i;
                                end
                            end else begin
                                bitcnt_q <= bitcnt_q + BCNT_W'(1);
                                if (mid_pt) lrck_q <= 1'b1;
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + HCNT_W'(1);
                    end
                end
                default: begin
                    hcnt_q <= '0;
                end
            endcase
        end
    end

    assign bck_o = bclk_q;
    assign lrc_o = lrck_q;

    // R6: frame clock moves only together with a falling bit clock
    p_lrc_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_q) |-> $fell(bclk_q));

    // R8: idle means both clocks at the inactive level
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!bclk_q && !lrck_q));

    // R8: the generator only stops at a frame boundary
    p_stop_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && ($past(st_q) != ST_IDLE)) |-> $past(bitcnt_q == frame_last));

    // R2: half-period counter stays within its terminal count
    p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt_q <= half_last);

    // R3: bit counter stays within the frame
    p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= frame_last);

endmodule

// File: rtl/aud_sclk_route.sv
module aud_sclk_route (
    input  logic gen_bck_i,
    input  logic gen_lrc_i,
    input  logic ext_bck_i,
    input  logic ext_lrc_i,
    input  logic tx_master_i,
    input  logic rx_master_i,
    input  logic inv_m_lrc_i,
    input  logic inv_m_bck_i,
    input  logic inv_s_lrc_i,
    input  logic inv_s_bck_i,
    output logic bck_pad_o,
    output logic lrc_pad_o,
    output logic pad_oe_o,
    output logic tx_bck_o,
    output logic tx_lrc_o,
    output logic rx_bck_o,
    output logic rx_lrc_o
);

    logic slv_bck, slv_lrc;

    always_comb begin
        slv_bck   = ext_bck_i ^ inv_s_bck_i;
        slv_lrc   = ext_lrc_i ^ inv_s_lrc_i;
        bck_pad_o = gen_bck_i ^ inv_m_bck_i;
        lrc_pad_o = gen_lrc_i ^ inv_m_lrc_i;
        pad_oe_o  = tx_master_i | rx_master_i;
        tx_bck_o  = tx_master_i ? gen_bck_i : slv_bck;
        tx_lrc_o  = tx_master_i ? gen_lrc_i : slv_lrc;
        rx_bck_o  = rx_master_i ? gen_bck_i : slv_bck;
        rx_lrc_o  = rx_master_i ? gen_lrc_i : slv_lrc;
    end

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
    import aud_sclk_pkg::*;
#(
    parameter int PORT_SEL = 0,
    parameter int HCNT_W   = MAX_HALF_LOG,
    parameter int BCNT_W   = MAX_FRAME_LOG
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] ckcfg_i,
    input  logic [15:0] polcfg_i,
    input  logic [7:0]  run_bus_i,
    input  logic        ext_bck_i,
    input  logic        ext_lrc_i,
    output logic        bck_pad_o,
    output logic        lrc_pad_o,
    output logic        pad_oe_o,
    output logic        tx_bck_o,
    output logic        tx_lrc_o,
    output logic        rx_bck_o,
    output logic        rx_lrc_o
);

    localparam int RATIO_LSB = 12;
    localparam int FRAME_LSB = 8;
    localparam int RX_MS_BIT = 4;
    localparam int TX_MS_BIT = 0;

    logic            run;
    logic [HL_W-1:0] dec_hl;
    logic [FL_W-1:0] dec_flog;
    logic            gen_bck, gen_lrc;
    logic            unused_bits;

    assign unused_bits = ^{ckcfg_i[15], ckcfg_i[11], ckcfg_i[7:5], ckcfg_i[3:1],
                           polcfg_i[15:13], polcfg_i[11:9], polcfg_i[7:5], polcfg_i[3:1],
                           run_bus_i};

    // pick this port's run bit
    generate
        if (PORT_SEL == 0) begin : g_port_a
            assign run = run_bus_i[0];
        end else begin : g_port_b
            assign run = run_bus_i[4];
        end
    endgenerate

    aud_sclk_decode u_dec (
        .ratio_code_i (ckcfg_i[RATIO_LSB +: 3]),
        .frame_code_i (ckcfg_i[FRAME_LSB +: 3]),
        .half_log_o   (dec_hl),
        .frame_log_o  (dec_flog)
    );

    aud_sclk_divider #(
        .HCNT_W (HCNT_W),
        .BCNT_W (BCNT_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .dec_hl_i   (dec_hl),
        .dec_flog_i (dec_flog),
        .bck_o      (gen_bck),
        .lrc_o      (gen_lrc)
    );

    aud_sclk_route u_route (
        .gen_bck_i   (gen_bck),
        .gen_lrc_i   (gen_lrc),
        .ext_bck_i   (ext_bck_i),
        .ext_lrc_i   (ext_lrc_i),
        .tx_master_i (ckcfg_i[TX_MS_BIT]),
        .rx_master_i (ckcfg_i[RX_MS_BIT]),
        .inv_m_lrc_i (polcfg_i[12]),
        .inv_m_bck_i (polcfg_i[8]),
        .inv_s_lrc_i (polcfg_i[4]),
        .inv_s_bck_i (polcfg_i[0]),
        .bck_pad_o   (bck_pad_o),
        .lrc_pad_o   (lrc_pad_o),
        .pad_oe_o    (pad_oe_o),
        .tx_bck_o    (tx_bck_o),
        .tx_lrc_o    (tx_lrc_o),
        .rx_bck_o    (rx_bck_o),
        .rx_lrc_o    (rx_lrc_o)
    );

    // R12: pads are driven only while some direction is master
    p_oe_master_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o |-> (ckcfg_i[TX_MS_BIT] || ckcfg_i[RX_MS_BIT]));

endmodule

// File: tb/sim_aud_sclk_gen.sv
`timescale 1ns/1ps
module sim_aud_sclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ckcfg_i = '0;
    logic [15:0] polcfg_i = '0;
    logic [7:0]  run_bus_i = '0;
    logic        ext_bck_i = 1'b0;
    logic        ext_lrc_i = 1'b0;
    logic bck_pad_o, lrc_pad_o, pad_oe_o, tx_bck_o, tx_lrc_o, rx_bck_o, rx_lrc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic pb = 1'b0;
    logic pl = 1'b0;

    always #2.5 clk = ~clk;

    aud_sclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .ckcfg_i(ckcfg_i), .polcfg_i(polcfg_i),
        .run_bus_i(run_bus_i), .ext_bck_i(ext_bck_i), .ext_lrc_i(ext_lrc_i),
        .bck_pad_o(bck_pad_o), .lrc_pad_o(lrc_pad_o), .pad_oe_o(pad_oe_o),
        .tx_bck_o(tx_bck_o), .tx_lrc_o(tx_lrc_o), .rx_bck_o(rx_bck_o), .rx_lrc_o(rx_lrc_o)
    );

    function automatic logic [15:0] mk_cfg(int ratio, int frame, bit rxm, bit txm);
        return {1'b0, 3'(ratio), 1'b0, 3'(frame), 3'b0, rxm, 3'b0, txm};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        pb = bck_pad_o;
        pl = lrc_pad_o;
        @(negedge clk);
    endtask

    task automatic do_reset();
        run_bus_i = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_bck_rise(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (!pb && bck_pad_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_lrc(bit rising, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            step();
            if (rising ? (!pl && lrc_pad_o) : (pl && !lrc_pad_o)) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure_period(string req, int exp);
        bit ok;
        int n = 0;
        wait_bck_rise(ok);
        for (int i = 0; i < 5000; i++) begin
            step();
            n++;
            if (!pb && bck_pad_o) break;
        end
        chk(req, ok ? n : -1, exp);
    endtask

    task automatic measure_half(string req, int exp_bits);
        bit ok;
        int falls = 0;
        wait_lrc(1'b1, ok);
        chk("R6 lrc rise on bck fall", (pb && !bck_pad_o) ? 1 : 0, 1);
        for (int i = 0; i < 5000; i++) begin
            step();
            if (pb && !bck_pad_o) falls++;
            if (pl && !lrc_pad_o) break;
        end
        chk("R6 lrc fall on bck fall", (pb && !bck_pad_o) ? 1 : 0, 1);
        chk(req, ok ? falls : -1, exp_bits);
    endtask

    task automatic start_run(int ratio, int frame);
        bit ok;
        ckcfg_i = mk_cfg(ratio, frame, 1'b0, 1'b1);
        polcfg_i = '0;
        do_reset();
        run_bus_i = 8'h01;
        wait_bck_rise(ok);
        chk("R6 first frame starts low", int'(lrc_pad_o), 0);
    endtask

    // R1 / R12: reset state
    task automatic t_reset();
        ckcfg_i = '0; polcfg_i = '0;
        do_reset();
        chk("R1 bck idle", int'(bck_pad_o), 0);
        chk("R1 lrc idle", int'(lrc_pad_o), 0);
        chk("R12 oe off", int'(pad_oe_o), 0);
    endtask

    // R2 / R3: several ratio and frame codes
    task automatic t_rates();
        start_run(0, 0); measure_period("R2 512/32 period", 16); measure_half("R3 32-bit frame", 16);
        start_run(1, 1); measure_period("R2 256/64 period", 4);  measure_half("R3 64-bit frame", 32);
        start_run(2, 2); measure_period("R2 128/128 period", 2); measure_half("R3 128-bit frame", 64);
        start_run(4, 7); measure_period("R2 32/16 period", 2);   measure_half("R3 16-bit frame", 8);
        start_run(0, 3); measure_period("R2 512/256 period", 2); measure_half("R3 256-bit frame", 128);
        chk("R12 oe with tx master", int'(pad_oe_o), 1);
    endtask

    // R4: fallback codes
    task automatic t_fallback();
        start_run(6, 5); measure_period("R4 fallback period", 16); measure_half("R4 fallback frame", 16);
        start_run(5, 6); measure_period("R4 fallback period 2", 16);
    endtask

    // R5: clamp when M < 2B
    task automatic t_clamp();
        start_run(3, 4); measure_period("R5 clamped period", 2); measure_half("R5 512-bit frame", 256);
    endtask

    // R7: the other port's run bit has no effect
    task automatic t_port_sel();
        int moved = 0;
        ckcfg_i = mk_cfg(4, 7, 1'b0, 1'b1);
        do_reset();
        run_bus_i = 8'h10;
        for (int i = 0; i < 200; i++) begin
            step();
            if (bck_pad_o || lrc_pad_o) moved++;
        end
        chk("R7 port B bit ignored", moved, 0);
    endtask

    // R8: stop completes the frame then holds low
    task automatic t_stop();
        bit ok;
        int bad = 0;
        start_run(0, 0);
        wait_lrc(1'b1, ok);
        run_bus_i = 8'h00;
        wait_bck_rise(ok);
        chk("R8 still toggling after clear", int'(ok), 1);
        wait_lrc(1'b0, ok);
        chk("R8 frame completed", int'(ok), 1);
        for (int i = 0; i < 100; i++) begin
            step();
            if (bck_pad_o || lrc_pad_o) bad++;
        end
        chk("R8 held inactive", bad, 0);
    endtask

    // R9: config change mid-frame applies at next frame
    task automatic t_reconfig();
        bit ok;
        start_run(0, 0);
        wait_lrc(1'b1, ok);
        ckcfg_i = mk_cfg(1, 1, 1'b0, 1'b1);
        measure_period("R9 old period kept", 16);
        wait_lrc(1'b0, ok);
        measure_period("R9 new period", 4);
        measure_half("R9 new frame", 32);
    endtask

    // R10: master inversion on pads
    task automatic t_pol_master();
        ckcfg_i = mk_cfg(0, 0, 1'b0, 1'b1);
        polcfg_i = 16'h1100;
        do_reset();
        chk("R10 bck pad inverted", int'(bck_pad_o), 1);
        chk("R10 lrc pad inverted", int'(lrc_pad_o), 1);
        chk("R10 tx bck uninverted", int'(tx_bck_o), 0);
    endtask

    // R11 / R12: slave routing and mixed roles
    task automatic t_slave();
        int mism = 0;
        ckcfg_i = mk_cfg(0, 0, 1'b0, 1'b0);
        polcfg_i = 16'h0011;
        do_reset();
        chk("R12 oe off in slave", int'(pad_oe_o), 0);
        ext_bck_i = 1'b1; ext_lrc_i = 1'b0; #0.5;
        chk("R11 tx bck slave inv", int'(tx_bck_o), 0);
        chk("R11 rx lrc slave inv", int'(rx_lrc_o), 1);
        polcfg_i = 16'h0000; #0.5;
        chk("R11 rx bck slave", int'(rx_bck_o), 1);
        chk("R11 tx lrc slave", int'(tx_lrc_o), 0);
        ckcfg_i = mk_cfg(4, 7, 1'b0, 1'b1);
        run_bus_i = 8'h01;
        for (int i = 0; i < 60; i++) begin
            step();
            if (tx_bck_o != bck_pad_o || rx_bck_o != 1'b1) mism++;
        end
        chk("R11 tx master rx slave", mism, 0);
        ckcfg_i = mk_cfg(4, 7, 1'b1, 1'b0); #0.5;
        chk("R12 oe with rx master", int'(pad_oe_o), 1);
        chk("R11 tx now slave", int'(tx_bck_o), 1);
        chk("R11 rx now master", int'(rx_bck_o), int'(bck_pad_o));
        ext_bck_i = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_rates();
        t_fallback();
        t_clamp();
        t_port_sel();
        t_stop();
        t_reconfig();
        t_pol_master();
        t_slave();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule